// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between the bit sampler and the frame field parser of a CAN receiver. Each sampled bus bit arrives with a strobe. The block counts how many identical bits in a row it has seen since the start of the frame. After a run of five equal bits, the next bit must have the opposite value. That bit is a stuff bit: the block reports it on its own strobe and keeps it out of the field stream. Every other bit is passed on to the parser with a data strobe. Every sampled bit, stuff or not, also produces a raw strobe that the bit timing logic counts.

A sixth equal bit in a row breaks the stuffing rule. The block then raises a one-cycle stuff error and goes idle until the next frame start. The parser drives a tail-zone level from the CRC delimiter onward. From that point on, bits are passed through without any stuffing check until the next frame start. A frame-start input clears the run counter. The bit presented together with frame start is taken as the start-of-frame bit, which opens the first run.

The controller has three states:
- IDLE, entered on reset and after a stuff error.
- ACTIVE, where stuffing is checked.
- TAIL, where bits pass through unchecked.

The transitions are:
- IDLE to ACTIVE on frame start.
- ACTIVE to TAIL when tail zone is high.
- ACTIVE to IDLE on a stuff error.
- Any state to ACTIVE on frame start.
- Any state to IDLE on reset.

All outputs are registered and appear one clock after the bit that caused them.

Top module: `can_destuffer`

## Requirements
- R1: Every cycle with raw_valid high gives raw_strobe high one cycle later, in every state and for stuff bits too. A cycle without raw_valid gives raw_strobe low one cycle later.
- R2: A bit accepted as a frame bit gives data_valid high one cycle later, with data_bit equal to the sampled bit. data_bit reads 0 whenever data_valid is low.
- R3: In ACTIVE, suppose five equal bits in a row have been received (bit value 0 or 1) and the next bit has the opposite value. That bit is a stuff bit: stuff_strobe goes high one cycle later and data_valid stays low.
- R4: A stuff bit counts as the first bit of the next run. Four more bits equal to it make that run five bits long, so the bit after them is again checked for stuffing.
- R5: In ACTIVE, a sixth equal bit after a run of five gives stuff_err high for one cycle, one cycle later. That bit is not forwarded. Until the next frame start, later bits produce only raw_strobe.
- R6: While tail_zone is high in ACTIVE, and in TAIL afterwards, every bit is forwarded as data, however long its run. No stuff_strobe or stuff_err is produced there.
- R7: frame_start clears the run count and enters ACTIVE from any state, taking priority over tail_zone. A bit sampled with frame_start is forwarded as data and is the first bit of a run. frame_start without raw_valid leaves the run empty.
- R8: In IDLE (after reset or after a stuff error), bits produce raw_strobe only: no data_valid, no stuff_strobe and no stuff_err.
- R9: The synchronous reset rst drives all outputs low one cycle later and returns the block to IDLE with an empty run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Start of a new frame; clears the run count |
| raw_valid | input | 1 | A sampled bus bit is present |
| raw_bit | input | 1 | Sampled bus bit value (0 dominant, 1 recessive) |
| tail_zone | input | 1 | From the parser: stuffing check ends (CRC delimiter onward) |
| raw_strobe | output | 1 | One pulse per sampled bit, stuff bits included |
| data_valid | output | 1 | Frame bit forwarded on data_bit |
| data_bit | output | 1 | Destuffed frame bit value |
| stuff_strobe | output | 1 | The sampled bit was a stuff bit and was dropped |
| stuff_err | output | 1 | Stuffing rule violated (sixth equal bit) |

## Verification
Several input patterns are applied, and each one tells two behaviours apart:
- Alternating bits never reach a full run, so any data loss they show is not caused by stuffing.
- A run of five zeros followed by a one shows whether the one is dropped as a stuff bit or forwarded.
- A stuff bit followed by four bits equal to it shows whether the stuff bit is counted as the start of the next run or is left out of it.
- A sixth equal bit separates error detection from silent forwarding.
- Runs of seven or more ones under tail_zone show that the check is really switched off in the tail.
- A frame start in the middle of a run shows whether the count is cleared there.
- Gaps without raw_valid between bits, and bits sent while idle, show that a run depends only on bit order and not on timing.

// File: rtl/can_dstf_pkg.sv
package can_dstf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_TAIL
    } dstf_state_e;

    typedef enum logic [1:0] {
        RUN_HOLD,
        RUN_CLEAR,
        RUN_RESTART,
        RUN_EXTEND
    } run_op_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_DATA,
        K_STUFF,
        K_ERR
    } bit_kind_e;

endpackage

// File: rtl/dstf_run_tracker.sv
module dstf_run_tracker
    import can_dstf_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    parameter int CNT_W     = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  run_op_e op,
    input  logic    bit_in,
    output logic    last_bit,
    output logic    run_empty,
    output logic    run_full
);

    logic [CNT_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len  <= '0;
            last_bit <= 1'b0;
        end else begin
            unique case (op)
                RUN_CLEAR:   run_len <= '0;
                RUN_RESTART: begin
                    run_len  <= CNT_W'(1);
                    last_bit <= bit_in;
                end
                RUN_EXTEND:  run_len <= run_len + 1'b1;
                default:     ;
            endcase
        end
    end

    assign run_empty = (run_len == '0);
    assign run_full  = (run_len == CNT_W'(RUN_LIMIT));

endmodule

// File: rtl/dstf_ctrl.sv
module dstf_ctrl
    import can_dstf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_start,
    input  logic    raw_valid,
    input  logic    raw_bit,
    input  logic    tail_zone,
    input  logic    last_bit,
    input  logic    run_empty,
    input  logic    run_full,
    output run_op_e op,
    output logic    raw_strobe,
    output logic    data_valid,
    output logic    data_bit,
    output logic    stuff_strobe,
    output logic    stuff_err
);

    dstf_state_e state, state_n;
    bit_kind_e   kind;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    always_comb begin
        state_n = state;
        op      = RUN_HOLD;
        kind    = K_NONE;
        if (frame_start) begin
            state_n = ST_ACTIVE;
            if (raw_valid) begin
                op   = RUN_RESTART;
                kind = K_DATA;
            end else begin
                op = RUN_CLEAR;
            end
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ACTIVE: begin
                    if (tail_zone) begin
                        state_n = ST_TAIL;
                        if (raw_valid) kind = K_DATA;
                    end else if (raw_valid) begin
                        if (run_empty) begin
                            op   = RUN_RESTART;
                            kind = K_DATA;
                        end else if (run_full) begin
                            if (raw_bit != last_bit) begin
                                op   = RUN_RESTART;
                                kind = K_STUFF;
                            end else begin
                                op      = RUN_CLEAR;
                                kind    = K_ERR;
                                state_n = ST_IDLE;
                            end
                        end else if (raw_bit == last_bit) begin
                            op   = RUN_EXTEND;
                            kind = K_DATA;
                        end else begin
                            op   = RUN_RESTART;
                            kind = K_DATA;
                        end
                    end
                end
                ST_TAIL: begin
                    if (raw_valid) kind = K_DATA;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_strobe   <= 1'b0;
            data_valid   <= 1'b0;
            data_bit     <= 1'b0;
            stuff_strobe <= 1'b0;
            stuff_err    <= 1'b0;
        end else begin
            raw_strobe   <= raw_valid;
            data_valid   <= (kind == K_DATA);
            data_bit     <= (kind == K_DATA) ? raw_bit : 1'b0;
            stuff_strobe <= (kind == K_STUFF);
            stuff_err    <= (kind == K_ERR);
        end
    end

endmodule

// File: rtl/can_destuffer.sv
module can_destuffer
    import can_dstf_pkg::*;
#(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic raw_valid,
    input  logic raw_bit,
    input  logic tail_zone,
    output logic raw_strobe,
    output logic data_valid,
    output logic data_bit,
    output logic stuff_strobe,
    output logic stuff_err
);

    localparam int CNT_W = $clog2(RUN_LIMIT + 1);

    run_op_e run_op;
    logic    last_bit;
    logic    run_empty;
    logic    run_full;

    dstf_run_tracker #(
        .RUN_LIMIT (RUN_LIMIT),
        .CNT_W     (CNT_W)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .op        (run_op),
        .bit_in    (raw_bit),
        .last_bit  (last_bit),
        .run_empty (run_empty),
        .run_full  (run_full)
    );

    dstf_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .raw_valid    (raw_valid),
        .raw_bit      (raw_bit),
        .tail_zone    (tail_zone),
        .last_bit     (last_bit),
        .run_empty    (run_empty),
        .run_full     (run_full),
        .op           (run_op),
        .raw_strobe   (raw_strobe),
        .data_valid   (data_valid),
        .data_bit     (data_bit),
        .stuff_strobe (stuff_strobe),
        .stuff_err    (stuff_err)
    );

endmodule

// File: rtl/can_destuffer_sva.sv
module dstf_checker (
    input logic clk,
    input logic rst,
    input logic frame_start,
    input logic raw_valid,
    input logic raw_bit,
    input logic tail_zone,
    input logic raw_strobe,
    input logic data_valid,
    input logic data_bit,
    input logic stuff_strobe,
    input logic stuff_err
);

    p_raw_follow_r1: assert property (@(posedge clk) disable iff (rst)
        raw_valid |=> raw_strobe);

    p_raw_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !raw_valid |=> !raw_strobe);

    p_data_copy_r2: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (data_bit == $past(raw_bit)));

    p_kind_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({data_valid, stuff_strobe, stuff_err}));

    p_stuff_raw_r3: assert property (@(posedge clk) disable iff (rst)
        stuff_strobe |-> raw_strobe);

    p_err_halt_r5: assert property (@(posedge clk) disable iff (rst)
        (stuff_err && !frame_start) |=> (!data_valid && !stuff_strobe && !stuff_err));

    p_tail_free_r6: assert property (@(posedge clk) disable iff (rst)
        (stuff_strobe || stuff_err) |-> !$past(tail_zone));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!raw_strobe && !data_valid && !data_bit && !stuff_strobe && !stuff_err));

endmodule

bind can_destuffer dstf_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .raw_valid    (raw_valid),
    .raw_bit      (raw_bit),
    .tail_zone    (tail_zone),
    .raw_strobe   (raw_strobe),
    .data_valid   (data_valid),
    .data_bit     (data_bit),
    .stuff_strobe (stuff_strobe),
    .stuff_err    (stuff_err)
);

// File: tb/sim_can_destuffer.sv
module sim_can_destuffer;

    localparam int PERIOD = 10;

    typedef struct {
        logic [4:0] v;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic raw_valid = 1'b0;
    logic raw_bit = 1'b0;
    logic tail_zone = 1'b0;
    logic raw_strobe, data_valid, data_bit, stuff_strobe, stuff_err;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    exp_t       q[$];
    exp_t       cur;
    logic [4:0] got;

    int         m_mode = 0;
    logic [5:0] hist = '0;
    int         hl = 0;

    always #(PERIOD/2) clk = ~clk;

    can_destuffer u0 (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .raw_valid    (raw_valid),
        .raw_bit      (raw_bit),
        .tail_zone    (tail_zone),
        .raw_strobe   (raw_strobe),
        .data_valid   (data_valid),
        .data_bit     (data_bit),
        .stuff_strobe (stuff_strobe),
        .stuff_err    (stuff_err)
    );

    // Monitor: the bit order of got and of the expected item is {raw, dv, db, stuff, err}.
    always @(posedge clk) begin
        #(PERIOD/4);
        if (q.size() > 0) begin
            cur = q.pop_front();
            got = {raw_strobe, data_valid, data_bit, stuff_strobe, stuff_err};
            checks++;
            if (got !== cur.v) begin
                bad++;
                $display("FAIL %s actual=%b expected=%b", cur.req, got, cur.v);
            end
        end
    end

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic cyc(input logic v, input logic b, input logic fs,
                       input logic tz, input logic r, input string req);
        exp_t e;
        @(negedge clk);
        raw_valid   = v;
        raw_bit     = b;
        frame_start = fs;
        tail_zone   = tz;
        rst         = r;
        e.v   = 5'b0;
        e.req = req;
        if (!r) e.v[4] = v;
        if (r) begin
            m_mode = 0;
            hl     = 0;
        end else if (fs) begin
            m_mode = 1;
            hl     = 0;
            if (v) begin
                e.v[3] = 1'b1;
                e.v[2] = b;
                hist   = {hist[4:0], b};
                hl     = 1;
            end
        end else if (m_mode == 1 && tz) begin
            m_mode = 2;
            if (v) begin
                e.v[3] = 1'b1;
                e.v[2] = b;
            end
        end else if (m_mode == 2) begin
            if (v) begin
                e.v[3] = 1'b1;
                e.v[2] = b;
            end
        end else if (m_mode == 1 && v) begin
            if (hl >= 5 && (hist[4:0] == 5'b00000 || hist[4:0] == 5'b11111)) begin
                if (b != hist[0]) begin
                    e.v[1] = 1'b1;
                    hist   = {hist[4:0], b};
                    if (hl < 6) hl++;
                end else begin
                    e.v[0] = 1'b1;
                    m_mode = 0;
                    hl     = 0;
                end
            end else begin
                e.v[3] = 1'b1;
                e.v[2] = b;
                hist   = {hist[4:0], b};
                if (hl < 6) hl++;
            end
        end
        q.push_back(e);
    endtask

    task automatic bits(input logic [31:0] pat, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) cyc(1'b1, pat[i], 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        // R9: reset state
        cyc(0, 0, 0, 0, 1, "R9");
        cyc(0, 0, 0, 0, 1, "R9");
        // R8: idle bits give raw strobe only
        bits(32'b1010_0000, 8, "R8");
        cyc(0, 0, 0, 0, 0, "R1");
        // R7: SOF with frame_start, then four zeros -> run of five
        cyc(1, 0, 1, 0, 0, "R7");
        bits(32'b0000, 4, "R3");
        // R3: opposite bit after five zeros is a stuff bit
        cyc(1, 1, 0, 0, 0, "R3");
        // R4: stuff bit starts the new run
        bits(32'b1111, 4, "R4");
        cyc(1, 0, 0, 0, 0, "R4");
        // R1/R2: gaps between bits, alternating data
        cyc(0, 0, 0, 0, 0, "R1");
        cyc(1, 0, 0, 0, 0, "R2");
        cyc(0, 1, 0, 0, 0, "R1");
        cyc(1, 1, 0, 0, 0, "R2");
        bits(32'b0101, 4, "R2");
        // R5: six equal bits -> error, then idle
        bits(32'b0000, 4, "R5");
        cyc(1, 0, 0, 0, 0, "R5");
        bits(32'b0101, 4, "R5");
        // R7: frame start mid run clears the count
        cyc(1, 1, 1, 0, 0, "R7");
        bits(32'b111, 3, "R7");
        cyc(1, 1, 1, 0, 0, "R7");
        bits(32'b1111, 4, "R7");
        cyc(1, 0, 0, 0, 0, "R7");
        // R6: tail zone forwards long runs
        cyc(1, 1, 0, 1, 0, "R6");
        bits(32'hFF, 8, "R6");
        cyc(1, 0, 0, 1, 0, "R6");
        bits(32'b0000000, 7, "R6");
        // R7: frame_start without a bit, then five zeros and a stuff one
        cyc(0, 0, 1, 1, 0, "R7");
        bits(32'b000001, 6, "R7");
        // R9: reset in mid-frame, then idle
        bits(32'b11, 2, "R9");
        cyc(1, 1, 0, 0, 1, "R9");
        bits(32'b11111111, 8, "R8");
        cyc(0, 0, 0, 0, 0, "R1");
        cyc(0, 0, 0, 0, 0, "R1");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule